// File: doc/BRIEF.md
# Fully Associative Read Cache with Selectable Replacement

This block is a small read-only cache between a word-addressed requester and a slower backing memory. A block of memory may be placed in any line. Each lookup compares the request tag with every stored tag at the same time. A hit returns the word on the cycle after the request is accepted.

On a miss, the block fetches the whole 8-word block over a request/acknowledge burst port, writes it into a line and then returns the word that was asked for. Empty lines are filled first, taking the lowest-numbered one. Only a full cache replaces a line. A parameter picks the replacement policy: fill-order FIFO or a free-running 16-bit LFSR.

Top module: `assoc_cache`

## Requirements
- R1: A 14-bit word address splits into a tag (bits 13..3) and a word offset (bits 2..0). During a fill, `mem_addr` carries the request tag and stays stable. The beats arrive in word order, offsets 0 to 7, one beat per cycle in which `mem_ack` is high.
- R2: After reset, every line is invalid, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R3: A request that meets a valid line holding its tag is a hit. On a hit, `rsp_valid` is 1 on the cycle after acceptance and carries the stored word, and no fill starts. At most one line matches any tag.
- R4: An invalid line never hits, so the first access to each block after reset is a miss.
- R5: On a miss, `mem_req` stays high and `req_ready` stays low until the 8th beat. All 8 words of the block are stored. `rsp_valid` rises on the cycle after the last beat with the requested word.
- R6: No line is replaced while any line is invalid. A miss fills the lowest-numbered invalid line, and that line is valid after its fill.
- R7: With the FIFO policy (`POLICY`=0), a miss in a full cache replaces the line filled earliest, whatever the read history. The pointer advances by one, modulo 16, on each replacement.
- R8: With the random policy (`POLICY`=1), the victim is bits 3..0 of a 16-bit LFSR with taps 16,14,13,11 that steps on every clock. The new block then hits, and some earlier block has been evicted.
- R9: Hits leave the stored contents and the replacement order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_addr | input | 14 | Word address of the request |
| req_ready | output | 1 | Cache can accept a request |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_data | output | 16 | Response word |
| mem_req | output | 1 | Block fetch request, held for the whole burst |
| mem_addr | output | 11 | Block address (tag) of the fetch |
| mem_ack | input | 1 | Beat valid on `mem_data` |
| mem_data | input | 16 | Burst data, offsets 0 to 7 in order |

## Verification
The assertions check the cycle rules on every cycle:
- the one-cycle hit response and the absence of a fetch after a hit;
- `req_ready` low during a fill and a stable fetch address;
- at most one matching line;
- filling only invalid lines while any remain, and the fill setting valid;
- the FIFO pointer step.

Only the bench's scenarios can show the rest. That covers correct data across whole blocks, the choice of FIFO victim over long mixed access streams checked against an independent model, a recently read block still being evicted first, and that random replacement evicts a resident block.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [0:0] {
    VICT_FIFO   = 1'b0,
    VICT_RANDOM = 1'b1
  } victim_policy_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } cache_state_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  // Fibonacci LFSR, taps 16,14,13,11 (maximal length)
  function automatic logic [15:0] lfsr16_step(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

endpackage

// File: rtl/tag_match.sv
module tag_match #(
  parameter int LINES = 16,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [TAG_W-1:0] look_tag,
  input  logic [LINES-1:0] valid_vec,
  input  logic [TAG_W-1:0] line_tag [LINES],
  output logic [LINES-1:0] match_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             all_valid,
  output logic [IDX_W-1:0] first_inv
);

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_cmp
      assign match_vec[g] = valid_vec[g] && (line_tag[g] == look_tag);
    end
  endgenerate

  assign hit       = |match_vec;
  assign all_valid = &valid_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  always_comb begin
    first_inv = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) first_inv = IDX_W'(i);
    end
  end

endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import cache_pkg::*;
#(
  parameter int LINES = 16,
  parameter victim_policy_e POLICY = VICT_FIFO,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx,
  output logic [IDX_W-1:0] fifo_ptr
);

  generate
    if (POLICY == VICT_FIFO) begin : g_fifo
      logic [IDX_W-1:0] ptr_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (advance) ptr_q <= ptr_q + 1'b1;
      end
      assign victim_idx = ptr_q;
      assign fifo_ptr   = ptr_q;
    end else begin : g_rand
      logic [15:0] lfsr_q;
      logic        unused_adv;
      assign unused_adv = advance;
      always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= lfsr16_step(lfsr_q);
      end
      assign victim_idx = lfsr_q[IDX_W-1:0];
      assign fifo_ptr   = '0;
    end
  endgenerate

endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int LINES  = 16,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int WORDS = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_line,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_line,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem_q [LINES*WORDS];

  function automatic int slot(input logic [IDX_W-1:0] l, input logic [OFF_W-1:0] o);
    return int'(l) * WORDS + int'(o);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[slot(wr_line, wr_off)] <= wr_data;
  end

  assign rd_data = mem_q[slot(rd_line, rd_off)];

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int OFF_W  = 3,
  parameter int LINES  = 16,
  parameter int DATA_W = 16,
  parameter victim_policy_e POLICY = VICT_FIFO,
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int IDX_W = $clog2(LINES),
  localparam int WORDS = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [TAG_W-1:0]  mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data
);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  cache_state_e      state_q;
  logic [LINES-1:0]  valid_vec;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [TAG_W-1:0]  req_tag_q;
  logic [OFF_W-1:0]  req_off_q;
  logic [IDX_W-1:0]  fill_idx;
  logic              fill_repl;
  logic [OFF_W-1:0]  beat_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [LINES-1:0]  match_vec;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              all_valid;
  logic [IDX_W-1:0]  first_inv;
  logic [IDX_W-1:0]  victim_idx;
  logic [IDX_W-1:0]  fifo_ptr;
  logic [IDX_W-1:0]  fill_pick;
  logic [DATA_W-1:0] rd_data;

  // named events for the checker
  logic accept, ev_hit_accept, ev_fill_start, ev_beat, ev_fill_done;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign ev_hit_accept = accept && hit;
  assign ev_fill_start = accept && !hit;
  assign ev_beat       = (state_q == ST_FILL) && mem_ack;
  assign ev_fill_done  = ev_beat && (beat_q == OFF_W'(WORDS - 1));
  assign fill_pick     = all_valid ? victim_idx : first_inv;

  tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
    .look_tag (tag_of(req_addr)),
    .valid_vec(valid_vec),
    .line_tag (tag_q),
    .match_vec(match_vec),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .all_valid(all_valid),
    .first_inv(first_inv)
  );

  victim_sel #(.LINES(LINES), .POLICY(POLICY)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (ev_fill_done && fill_repl),
    .victim_idx(victim_idx),
    .fifo_ptr  (fifo_ptr)
  );

  line_store #(.LINES(LINES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .wr_en  (ev_beat),
    .wr_line(fill_idx),
    .wr_off (beat_q),
    .wr_data(mem_data),
    .rd_line(hit_idx),
    .rd_off (off_of(req_addr)),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      valid_vec   <= '0;
      req_tag_q   <= '0;
      req_off_q   <= '0;
      fill_idx    <= '0;
      fill_repl   <= 1'b0;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ev_hit_accept) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= rd_data;
          end else if (ev_fill_start) begin
            state_q   <= ST_FILL;
            req_tag_q <= tag_of(req_addr);
            req_off_q <= off_of(req_addr);
            fill_idx  <= fill_pick;
            fill_repl <= all_valid;
            beat_q    <= '0;
            valid_vec[fill_pick] <= 1'b0;
          end
        end
        ST_FILL: begin
          if (ev_beat) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == req_off_q) rsp_data_q <= mem_data;
          end
          if (ev_fill_done) begin
            state_q             <= ST_IDLE;
            valid_vec[fill_idx] <= 1'b1;
            tag_q[fill_idx]     <= req_tag_q;
            rsp_valid_q         <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign mem_req   = (state_q == ST_FILL);
  assign mem_addr  = req_tag_q;

endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk
  import cache_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 11,
  parameter victim_policy_e POLICY = VICT_FIFO,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_req,
  input logic [TAG_W-1:0] mem_addr,
  input logic             ev_hit_accept,
  input logic             ev_fill_start,
  input logic             ev_fill_done,
  input logic             fill_repl,
  input logic [IDX_W-1:0] fill_idx,
  input logic [IDX_W-1:0] fill_pick,
  input logic [LINES-1:0] valid_vec,
  input logic [LINES-1:0] match_vec,
  input logic             all_valid,
  input logic [IDX_W-1:0] fifo_ptr
);

  AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_accept |=> rsp_valid); // R3

  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_accept |=> !mem_req); // R3

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R3

  AST_READY_LOW_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R5

  AST_MEMADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr)); // R1

  AST_FILL_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill_start && !all_valid) |-> !valid_vec[fill_pick]); // R6

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> valid_vec[$past(fill_idx)]); // R6

  AST_FIFO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == VICT_FIFO && ev_fill_done && fill_repl) |=>
      (fifo_ptr == IDX_W'($past(fifo_ptr) + 1'b1))); // R7

  AST_FIFO_HOLD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == VICT_FIFO && ev_hit_accept) |=> $stable(fifo_ptr)); // R9

endmodule

bind assoc_cache assoc_cache_chk #(.LINES(LINES), .TAG_W(TAG_W), .POLICY(POLICY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .ev_hit_accept(ev_hit_accept),
  .ev_fill_start(ev_fill_start),
  .ev_fill_done (ev_fill_done),
  .fill_repl    (fill_repl),
  .fill_idx     (fill_idx),
  .fill_pick    (fill_pick),
  .valid_vec    (valid_vec),
  .match_vec    (match_vec),
  .all_valid    (all_valid),
  .fifo_ptr     (fifo_ptr)
);

// File: tb/assoc_cache_test.sv
module assoc_cache_test;
  import cache_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        sel = 1'b0;  // 0: FIFO instance, 1: random instance
  logic        req_valid = 1'b0;
  logic [13:0] req_addr = '0;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_data = '0;

  logic        rdy_f, rv_f, mreq_f, rdy_r, rv_r, mreq_r;
  logic [15:0] rd_f, rd_r;
  logic [10:0] ma_f, ma_r;

  assoc_cache #(.POLICY(VICT_FIFO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel), .req_addr(req_addr),
    .req_ready(rdy_f), .rsp_valid(rv_f), .rsp_data(rd_f), .mem_req(mreq_f),
    .mem_addr(ma_f), .mem_ack(mem_ack && !sel), .mem_data(mem_data));

  assoc_cache #(.POLICY(VICT_RANDOM)) uut_rnd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel), .req_addr(req_addr),
    .req_ready(rdy_r), .rsp_valid(rv_r), .rsp_data(rd_r), .mem_req(mreq_r),
    .mem_addr(ma_r), .mem_ack(mem_ack && sel), .mem_data(mem_data));

  wire        c_rdy  = sel ? rdy_r  : rdy_f;
  wire        c_rv   = sel ? rv_r   : rv_f;
  wire [15:0] c_rd   = sel ? rd_r   : rd_f;
  wire        c_mreq = sel ? mreq_r : mreq_f;
  wire [10:0] c_ma   = sel ? ma_r   : ma_f;

  int checks = 0;
  int failures = 0;

  function automatic logic [15:0] mem_word(input logic [13:0] a);
    return 16'(int'(a) * 7 + 16'h5A31);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // backing memory: one beat every other cycle, offsets in order
  initial begin
    int beat = 0;
    bit gap = 0;
    forever begin
      @(negedge clk);
      if (c_mreq && beat < 8) begin
        if (gap) begin
          mem_ack = 1'b0;
          gap = 0;
        end else begin
          mem_ack  = 1'b1;
          mem_data = mem_word({c_ma, 3'(beat)});
          beat++;
          gap = 1;
        end
      end else begin
        mem_ack = 1'b0;
        if (!c_mreq) begin
          beat = 0;
          gap = 0;
        end
      end
    end
  end

  // read one word, report data and whether it was a one-cycle hit
  task automatic rd(input logic [13:0] a, output logic [15:0] d, output bit was_hit,
                    output bit rdy_after);
    int cyc;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!c_rdy) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdy_after = c_rdy;
    cyc = 1;
    while (!c_rv && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    d = c_rd;
    was_hit = (cyc == 1);
  endtask

  // FIFO reference model
  logic [10:0] m_tag [16];
  bit          m_val [16];
  int          m_cnt, m_ptr;

  task automatic model_access(input logic [10:0] t, output bit h);
    h = 0;
    for (int i = 0; i < 16; i++) if (m_val[i] && m_tag[i] == t) h = 1;
    if (!h) begin
      if (m_cnt < 16) begin
        m_tag[m_cnt] = t; m_val[m_cnt] = 1; m_cnt++;
      end else begin
        m_tag[m_ptr] = t; m_ptr = (m_ptr + 1) % 16;
      end
    end
  endtask

  task automatic access_cmp(input logic [13:0] a, input string req);
    logic [15:0] d; bit h, eh, ra;
    model_access(a[13:3], eh);
    rd(a, d, h, ra);
    check(h == eh, req, h, eh);
    check(d == mem_word(a), req, d, mem_word(a));
    if (!eh) check(ra == 1'b0, "R5 ready low during fill", ra, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d; bit h, ra, found;
    for (int i = 0; i < 16; i++) m_val[i] = 0;
    m_cnt = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    check(rdy_f == 1 && rv_f == 0 && mreq_f == 0, "R2 reset state fifo",
          {rdy_f, rv_f, mreq_f}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy_f == 1 && rv_f == 0 && mreq_f == 0, "R2 idle after reset",
          {rdy_f, rv_f, mreq_f}, 3'b100);

    // R4/R6: 16 distinct blocks all miss on first touch, none evicted
    for (int b = 0; b < 16; b++)
      access_cmp({11'(b * 37 + 5), 3'(b % 8)}, "R4 first touch misses");
    // R1/R3/R5: every word of every resident block hits with memory data
    for (int b = 0; b < 16; b++)
      for (int o = 0; o < 8; o++)
        access_cmp({11'(b * 37 + 5), 3'(o)}, "R3 whole block hits");
    // R1: same offset, tag differing in top bit misses
    // R7: block filled first goes out even though just read (FIFO)
    access_cmp({11'(5), 3'd2}, "R9 hit keeps order");
    access_cmp({11'h405, 3'd2}, "R1 tag alias misses");
    access_cmp({11'(5), 3'd2}, "R7 earliest filled evicted");
    access_cmp({11'(42), 3'd7}, "R7 second victim evicted");
    // mixed stream against the model
    for (int i = 0; i < 400; i++)
      access_cmp({11'(((i * 7 + (i / 5) * 3) % 21) * 37 + 5), 3'((i * 5) % 8)},
                 "R7 stream vs model");

    // random policy instance
    @(negedge clk);
    sel = 1'b1;
    @(negedge clk);
    check(rdy_r == 1 && rv_r == 0 && mreq_r == 0, "R2 reset state random",
          {rdy_r, rv_r, mreq_r}, 3'b100);
    for (int b = 0; b < 16; b++) begin
      rd({11'(b + 100), 3'd1}, d, h, ra);
      check(!h, "R6 random fill no hit", h, 0);
      check(d == mem_word({11'(b + 100), 3'd1}), "R5 random fill data", d,
            mem_word({11'(b + 100), 3'd1}));
    end
    for (int b = 0; b < 16; b++) begin
      rd({11'(b + 100), 3'd6}, d, h, ra);
      check(h, "R6 no eviction before full", h, 1);
    end
    rd({11'd999, 3'd4}, d, h, ra);
    check(!h && d == mem_word({11'd999, 3'd4}), "R8 new block miss", d,
          mem_word({11'd999, 3'd4}));
    rd({11'd999, 3'd0}, d, h, ra);
    check(h && d == mem_word({11'd999, 3'd0}), "R8 new block resident", d,
          mem_word({11'd999, 3'd0}));
    found = 0;
    for (int b = 0; b < 16; b++) begin
      if (!found) begin
        rd({11'(b + 100), 3'd3}, d, h, ra);
        check(d == mem_word({11'(b + 100), 3'd3}), "R8 data after replace", d,
              mem_word({11'(b + 100), 3'd3}));
        if (!h) found = 1;
      end
    end
    check(found, "R8 some old block evicted", found, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule